// File: doc/BRIEF.md
# Dual-Source Reloadable Interrupt Counter

This block raises an interrupt after a programmed number of events. An 8-bit counter counts down and reloads itself. Its clock comes from one of two sources:

- Scanline source: filtered rising edges of video address line 12, which arrive roughly once per scanline.
- Cycle source: a divide-by-four prescaler that runs on the CPU clock enable.

Software uses four write strobes, which share one 8-bit data bus:

- Store a reload value.
- Select the source and arm a forced reload.
- Acknowledge the request and disable interrupts.
- Enable interrupts.

When the counter reaches zero and interrupts are enabled, the request output is raised after a short delay. The delay is counted in CPU clock enables. The request stays high until it is acknowledged.

All state changes on the rising edge of `clk`, and reset is synchronous and active high. The CPU clock enable `cpu_ce` marks the CPU cycles. Every write strobe is sampled on any rising edge at which it is high. A counter clock that lands on the same edge as a write uses the register values from before that write.

Top module: `dual_src_irq_counter`

## Requirements
- R1: A `wr_latch` strobe stores all 8 bits of `wr_data` as the reload value. The next reload uses this value.
- R2: A `wr_mode` strobe selects the source from `wr_data` bit 0: 0 selects filtered A12 edges and 1 selects the prescaled CPU cycles. The source that is not selected never clocks the counter.
- R3: In cycle mode, the counter is clocked on every fourth edge with `cpu_ce` high. A `wr_mode` strobe restarts the prescaler, so the first clock after it comes on the fourth `cpu_ce` edge after the write edge.
- R4: A `wr_mode` strobe arms a forced reload. The next counter clock loads the reload value plus one, modulo 256, and disarms it; a reload value of 255 therefore loads 0.
- R5: On a counter clock with no forced reload armed, a count of zero reloads from the reload value. Any other count decrements, and a decrement that reaches zero is a trigger if interrupts are enabled.
- R6: While interrupts are disabled, the counter keeps clocking, decrementing and reloading, but `irq` stays low.
- R7: A `wr_ack` strobe disables interrupts, clears `irq` on the next edge, and cancels any trigger still waiting out its delay, including a trigger on the same edge.
- R8: A `wr_enable` strobe enables interrupts, starting with the next counter clock.
- R9: An A12 rising edge clocks the counter only if A12 was sampled low on at least A12_LOW_MIN consecutive `cpu_ce` edges just before it. Shorter low pulses are ignored.
- R10: `irq` rises on the IRQ_DELAY-th `cpu_ce` edge after the triggering edge, and it stays high until a `wr_ack` strobe.
- R11: After reset, `irq` is low, interrupts are disabled, the A12 source is selected, and the count and reload value are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ce | input | 1 | CPU cycle clock enable |
| vid_a12 | input | 1 | Video address line 12 |
| wr_latch | input | 1 | Strobe: store the reload value |
| wr_mode | input | 1 | Strobe: select the source and arm a forced reload |
| wr_ack | input | 1 | Strobe: acknowledge the request and disable interrupts |
| wr_enable | input | 1 | Strobe: enable interrupts |
| wr_data | input | 8 | Write data |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that `vid_a12` and the strobes are synchronous to `clk`, and that IRQ_DELAY, A12_LOW_MIN and the prescaler divisor stay at one or more, or two or more for the divisor. The sticky-request property assumes that only an acknowledge strobe removes the request. The stimulus changes every input once per clock, away from the active edge. Its random phase asserts at most one write strobe per cycle, so acknowledge and enable never share a cycle. A12 pulses are drawn both shorter and longer than the filter threshold.

// File: rtl/irq_cnt_pkg.sv
package irq_cnt_pkg;

    localparam int CNT_W = 8;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic {
        SRC_A12 = 1'b0,
        SRC_CPU = 1'b1
    } clk_src_e;

    typedef struct packed {
        cnt_t value;
        logic zero_hit;
    } cnt_step_t;

    // One counter clock: forced reload, zero reload, or decrement.
    function automatic cnt_step_t count_step(cnt_t cur, cnt_t reload, logic force_rl);
        cnt_step_t s;
        s.zero_hit = 1'b0;
        if (force_rl) begin
            s.value = reload + cnt_t'(1);
        end else if (cur == '0) begin
            s.value = reload;
        end else begin
            s.value    = cur - cnt_t'(1);
            s.zero_hit = (s.value == '0);
        end
        return s;
    endfunction

endpackage

// File: rtl/irq_a12_filter.sv
module irq_a12_filter #(
    parameter int LOW_MIN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic cpu_ce,
    input  logic a12,
    output logic edge_tick
);
    localparam int LW = $clog2(LOW_MIN + 1);

    logic          a12_q;
    logic [LW-1:0] low_cnt;

    assign edge_tick = a12 && !a12_q && (low_cnt >= LW'(LOW_MIN));

    always_ff @(posedge clk) begin
        if (rst) begin
            a12_q   <= 1'b1;
            low_cnt <= '0;
        end else begin
            a12_q <= a12;
            if (a12) begin
                low_cnt <= '0;
            end else if (cpu_ce && (low_cnt < LW'(LOW_MIN))) begin
                low_cnt <= low_cnt + LW'(1);
            end
        end
    end

    // R9: an accepted edge can never be followed directly by another
    p_single_edge_r9: assert property (@(posedge clk) disable iff (rst)
        edge_tick |=> !edge_tick);

endmodule

// File: rtl/irq_prescaler.sv
module irq_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic cpu_ce,
    input  logic clear,
    output logic div_tick
);
    localparam int PW = $clog2(DIV);

    logic [PW-1:0] pcnt;
    logic          at_end;

    assign at_end   = (pcnt == PW'(DIV - 1));
    assign div_tick = cpu_ce && !clear && at_end;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pcnt <= '0;
        end else if (cpu_ce) begin
            pcnt <= at_end ? '0 : pcnt + PW'(1);
        end
    end

    // R3: consecutive ticks are always separated
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
        div_tick |=> !div_tick);

    // R3: a restart leaves the phase at the beginning
    p_clear_restart_r3: assert property (@(posedge clk) disable iff (rst)
        clear |=> (pcnt == '0));

endmodule

// File: rtl/irq_reload_counter.sv
module irq_reload_counter
    import irq_cnt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic wr_latch,
    input  logic wr_mode,
    input  logic wr_ack,
    input  logic wr_enable,
    input  cnt_t wr_data,
    output logic trigger
);
    cnt_t      count_q;
    cnt_t      reload_q;
    logic      force_q;
    logic      en_q;
    cnt_step_t step;

    assign step    = count_step(count_q, reload_q, force_q);
    assign trigger = tick && step.zero_hit && en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            reload_q <= '0;
            force_q  <= 1'b0;
            en_q     <= 1'b0;
        end else begin
            if (tick) begin
                count_q <= step.value;
            end
            if (wr_latch) begin
                reload_q <= wr_data;
            end
            if (wr_mode) begin
                force_q <= 1'b1;
            end else if (tick) begin
                force_q <= 1'b0;
            end
            if (wr_ack) begin
                en_q <= 1'b0;
            end else if (wr_enable) begin
                en_q <= 1'b1;
            end
        end
    end

    // R4: a forced reload loads value plus one and disarms
    p_force_load_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && force_q && !wr_mode) |=>
            (!force_q && (count_q == $past(reload_q) + cnt_t'(1))));

    // R5: an unforced clock at zero takes the reload value
    p_zero_reload_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !force_q && (count_q == '0)) |=> (count_q == $past(reload_q)));

    // R5: the count only moves on a counter clock
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count_q));

endmodule

// File: rtl/irq_assert_delay.sv
module irq_assert_delay #(
    parameter int DELAY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cpu_ce,
    input  logic trigger,
    input  logic ack,
    output logic irq
);
    localparam int DW = $clog2(DELAY + 1);

    logic          busy;
    logic [DW-1:0] dcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            dcnt <= '0;
            irq  <= 1'b0;
        end else if (ack) begin
            busy <= 1'b0;
            irq  <= 1'b0;
        end else if (trigger) begin
            busy <= 1'b1;
            dcnt <= DW'(DELAY);
        end else if (busy && cpu_ce) begin
            if (dcnt == DW'(1)) begin
                busy <= 1'b0;
                irq  <= 1'b1;
            end else begin
                dcnt <= dcnt - DW'(1);
            end
        end
    end

    // R7: acknowledge drops the request
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
        ack |=> !irq);

    // R10: request holds until acknowledged
    p_irq_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (irq && !ack) |=> irq);

    // R10: request only rises at the end of a pending wait
    p_rise_after_wait_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(busy));

endmodule

// File: rtl/dual_src_irq_counter.sv
module dual_src_irq_counter
    import irq_cnt_pkg::*;
#(
    parameter int A12_LOW_MIN = 3,
    parameter int PRESCALE    = 4,
    parameter int IRQ_DELAY   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_ce,
    input  logic       vid_a12,
    input  logic       wr_latch,
    input  logic       wr_mode,
    input  logic       wr_ack,
    input  logic       wr_enable,
    input  logic [7:0] wr_data,
    output logic       irq
);
    clk_src_e src_q;
    logic     edge_tick;
    logic     div_tick;
    logic     cnt_tick;
    logic     trigger;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= SRC_A12;
        end else if (wr_mode) begin
            src_q <= clk_src_e'(wr_data[0]);
        end
    end

    irq_a12_filter #(.LOW_MIN(A12_LOW_MIN)) u_filter (
        .clk       (clk),
        .rst       (rst),
        .cpu_ce    (cpu_ce),
        .a12       (vid_a12),
        .edge_tick (edge_tick)
    );

    irq_prescaler #(.DIV(PRESCALE)) u_presc (
        .clk      (clk),
        .rst      (rst),
        .cpu_ce   (cpu_ce),
        .clear    (wr_mode),
        .div_tick (div_tick)
    );

    assign cnt_tick = (src_q == SRC_CPU) ? div_tick : edge_tick;

    irq_reload_counter u_counter (
        .clk       (clk),
        .rst       (rst),
        .tick      (cnt_tick),
        .wr_latch  (wr_latch),
        .wr_mode   (wr_mode),
        .wr_ack    (wr_ack),
        .wr_enable (wr_enable),
        .wr_data   (cnt_t'(wr_data)),
        .trigger   (trigger)
    );

    irq_assert_delay #(.DELAY(IRQ_DELAY)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .cpu_ce  (cpu_ce),
        .trigger (trigger),
        .ack     (wr_ack),
        .irq     (irq)
    );

endmodule

// File: tb/test_dual_src_irq_counter.sv
module test_dual_src_irq_counter;
    localparam int CLK_PERIOD = 10;
    localparam int LOW_MIN    = 3;
    localparam int DIV        = 4;
    localparam int DLY        = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_ce = 1'b1;
    logic       vid_a12 = 1'b0;
    logic       wr_latch = 1'b0;
    logic       wr_mode = 1'b0;
    logic       wr_ack = 1'b0;
    logic       wr_enable = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       irq;

    int checks = 0;
    int errors = 0;

    dual_src_irq_counter #(
        .A12_LOW_MIN (LOW_MIN),
        .PRESCALE    (DIV),
        .IRQ_DELAY   (DLY)
    ) i_dual_src_irq_counter (
        .clk       (clk),
        .rst       (rst),
        .cpu_ce    (cpu_ce),
        .vid_a12   (vid_a12),
        .wr_latch  (wr_latch),
        .wr_mode   (wr_mode),
        .wr_ack    (wr_ack),
        .wr_enable (wr_enable),
        .wr_data   (wr_data),
        .irq       (irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Reference state built from the requirements
    int m_low, m_a12q, m_pre, m_mode, m_force, m_cnt, m_latch, m_en, m_busy, m_d, m_irq;

    always @(posedge clk) begin
        int atick, ptick, tk, trig;
        if (rst) begin
            m_low = 0; m_a12q = 1; m_pre = 0; m_mode = 0; m_force = 0;
            m_cnt = 0; m_latch = 0; m_en = 0; m_busy = 0; m_d = 0; m_irq = 0;
        end else begin
            atick = (vid_a12 && m_a12q == 0 && m_low >= LOW_MIN) ? 1 : 0;
            if (vid_a12) m_low = 0;
            else if (cpu_ce && m_low < LOW_MIN) m_low = m_low + 1;
            m_a12q = vid_a12 ? 1 : 0;
            ptick = 0;
            if (wr_mode) m_pre = 0;
            else if (cpu_ce) begin
                if (m_pre == DIV - 1) begin ptick = 1; m_pre = 0; end
                else m_pre = m_pre + 1;
            end
            tk = m_mode ? ptick : atick;
            trig = 0;
            if (tk) begin
                if (m_force) begin m_cnt = (m_latch + 1) % 256; m_force = 0; end
                else if (m_cnt == 0) m_cnt = m_latch;
                else begin
                    m_cnt = m_cnt - 1;
                    trig = (m_cnt == 0 && m_en) ? 1 : 0;
                end
            end
            if (wr_ack) begin m_irq = 0; m_busy = 0; end
            else if (trig) begin m_busy = 1; m_d = DLY; end
            else if (m_busy && cpu_ce) begin
                if (m_d == 1) begin m_irq = 1; m_busy = 0; end
                else m_d = m_d - 1;
            end
            if (wr_latch) m_latch = int'(wr_data);
            if (wr_mode) begin m_mode = int'(wr_data[0]); m_force = 1; end
            if (wr_ack) m_en = 0;
            else if (wr_enable) m_en = 1;
        end
    end

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: irq=%0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the reference (R10 timing and all rules)
    always @(negedge clk) begin
        if (!rst) chk("R10 model", irq, m_irq[0]);
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // kind: 0 reload value, 1 mode, 2 acknowledge, 3 enable
    task automatic wr(input int kind, input logic [7:0] d);
        wr_data   = d;
        wr_latch  = (kind == 0);
        wr_mode   = (kind == 1);
        wr_ack    = (kind == 2);
        wr_enable = (kind == 3);
        @(posedge clk);
        @(negedge clk);
        wr_latch = 1'b0; wr_mode = 1'b0; wr_ack = 1'b0; wr_enable = 1'b0;
    endtask

    task automatic a12_pulse(input int lows, input int highs);
        vid_a12 = 1'b0;
        step(lows);
        vid_a12 = 1'b1;
        step(highs);
        vid_a12 = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: irq=%0b expected run end", irq);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed_val;
        seed_val = $urandom(32'd20240611);
        @(negedge clk);
        step(3);
        rst = 1'b0;
        step(1);
        chk("R11 reset", irq, 1'b0);
        wr(3, 8'h00);
        step(20);
        chk("R11 idle", irq, 1'b0);

        // Cycle mode, reload value 3: forced 4, then 3,2,1,0 -> trigger at edge 20
        wr(2, 8'h00);
        wr(0, 8'd3);
        wr(3, 8'h00);
        wr(1, 8'h01);
        step(21);
        chk("R3 before delay", irq, 1'b0);
        step(1);
        chk("R1/R5 assert", irq, 1'b1);
        step(10);
        chk("R10 sticky", irq, 1'b1);
        wr(2, 8'h00);
        chk("R7 ack", irq, 1'b0);
        step(30);
        chk("R6 disabled", irq, 1'b0);
        wr(3, 8'h00);
        step(5);
        chk("R8 before", irq, 1'b0);
        step(1);
        chk("R8 enabled", irq, 1'b1);

        // Reload value 255: forced load wraps to 0
        wr(2, 8'h00);
        wr(0, 8'd255);
        wr(1, 8'h01);
        wr(3, 8'h00);
        step(1028);
        chk("R4 wrap before", irq, 1'b0);
        step(1);
        chk("R4 wrap", irq, 1'b1);

        // A12 source: cycle prescaler must not clock the counter
        wr(2, 8'h00);
        wr(1, 8'h00);
        wr(0, 8'd1);
        wr(3, 8'h00);
        step(40);
        chk("R2 source", irq, 1'b0);
        a12_pulse(4, 2);
        a12_pulse(1, 2);
        a12_pulse(4, 2);
        a12_pulse(2, 2);
        chk("R9 short lows", irq, 1'b0);
        a12_pulse(3, 2);
        chk("R9 delay", irq, 1'b0);
        step(1);
        chk("R9 accepted", irq, 1'b1);

        // Random phase, compared against the reference each cycle
        wr(2, 8'h00);
        for (int i = 0; i < 6000; i++) begin
            int r;
            cpu_ce = (($urandom % 10) < 7);
            if (($urandom % 3) == 0) vid_a12 = ~vid_a12;
            wr_latch = 1'b0; wr_mode = 1'b0; wr_ack = 1'b0; wr_enable = 1'b0;
            r = $urandom % 100;
            wr_data = (($urandom % 8) == 0) ? 8'(($urandom % 2) * 255) : 8'($urandom % 6);
            if (r < 2) wr_latch = 1'b1;
            else if (r < 4) wr_mode = 1'b1;
            else if (r < 6) wr_ack = 1'b1;
            else if (r < 9) wr_enable = 1'b1;
            @(negedge clk);
        end
        wr_latch = 1'b0; wr_mode = 1'b0; wr_ack = 1'b0; wr_enable = 1'b0;
        step(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule